// File: doc/BRIEF.md
# Parallel Port Control Line Handler

This block watches and drives the two handshake lines that belong to each data port of a parallel interface. Each port has a first line that is always an input and a second line that is either an input or an output. On every clock the block samples all input lines and compares each sample with the one kept from the clock before. A programmed transition sets a per-line flag. A flag stays set until an access to the data register of its own port clears it.

A control word written over the register bus sets up the lines. Each port has a 4-bit field in that word. The low bit of the field picks the active transition of the first line. The upper three bits pick one of eight behaviours for the second line: four input behaviours and four output behaviours. Two of the input behaviours are "independent": on ports built with that option, a data access leaves the second-line flag alone. In the output behaviours the second line works in one of four ways. In handshake mode, a data access pulls it low and the next change on the first line raises it again. In pulse mode, a data access pulls it low for a programmed number of cycles. The other two output behaviours hold it at a fixed level. The block's outputs are the flags, the line drive and the line enable. A separate unit combines the flags into an interrupt.

Top module: `ctl_line_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the control word and all flags. It releases every second line (`l2_oe` low, `l2_out` high) and loads the stored previous samples with the current pin levels. If the pins hold their level after reset, no flag is set.
- R2: `cfg_wr` at a clock edge loads `cfg_wdata` into the control word. Port p owns bits [4p+3:4p]. Bit 4p is the first-line edge select and bits [4p+3:4p+1] are the second-line mode. Port 0 is port A and port 1 is port B.
- R3: The first-line flag of a port is set at the clock edge where the sampled level differs from the previous sample in the selected direction. Edge select 0 means high-to-low and edge select 1 means low-to-high.
- R4: Second-line modes 0 to 3 are inputs. Modes 0 and 1 set the second-line flag on a high-to-low change, and modes 2 and 3 set it on a low-to-high change. In modes 4 to 7 the flag is never set.
- R5: A `port_acc` pulse for port B clears both of its flags at that edge. If a selected edge arrives in the same cycle as the access, that flag is set rather than cleared. An access to one port leaves the other port's flags unchanged.
- R6: A `port_acc` pulse for port A clears its first-line flag. It also clears its second-line flag, except in modes 1 and 3, where that flag keeps its value.
- R7: In mode 4 (handshake), the line is enabled. It goes low in the cycle after a data access and goes high after any change on the same port's first line. If the access and the change fall in the same cycle, the access wins.
- R8: In mode 5 (pulse), the line is enabled. It goes low for PULSE_CYCLES cycles (1 by default), starting in the cycle after a data access, and then returns high. A new access restarts the low period.
- R9: Mode 6 drives the line low and mode 7 drives it high, both with the enable set.
- R10: In modes 0 to 3 the enable is low and `l2_out` is high.
- R11: Leaving mode 4 or mode 5 returns that port's output state to high, so a later return to either mode starts with the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 4*PORTS | Control word write data |
| port_acc | input | PORTS | Per-port data register access pulse (read or write) |
| l1_in | input | PORTS | First control line level per port |
| l2_in | input | PORTS | Second control line input level per port |
| flag_l1 | output | PORTS | First-line event flags |
| flag_l2 | output | PORTS | Second-line event flags |
| l2_out | output | PORTS | Second-line drive value |
| l2_oe | output | PORTS | Second-line output enable |

## Verification
Directed sequences drive each line through both transition directions under both edge selects, which separates a correct polarity decode from an inverted or missing one. Accesses are timed to land with and without a same-cycle edge, showing whether set beats clear. On port A they are also made in dependent and independent modes, which separates the flag-keeping exception from an unconditional clear. For the output modes, accesses are followed by a first-line change, a same-cycle change, a repeated access and a mode round trip, which tells apart the handshake release, the access priority, the pulse restart and the idle-state return. Long stretches with random pin toggles, accesses and control word rewrites are then compared cycle by cycle against a model built from the requirements.

// File: rtl/ctl_line_pkg.sv
package ctl_line_pkg;

   localparam int FIELD_W = 4;

   typedef enum logic [2:0] {
      L2_IN_NEG      = 3'd0,
      L2_IN_NEG_IND  = 3'd1,
      L2_IN_POS      = 3'd2,
      L2_IN_POS_IND  = 3'd3,
      L2_HANDSHAKE   = 3'd4,
      L2_PULSE       = 3'd5,
      L2_FORCE_LO    = 3'd6,
      L2_FORCE_HI    = 3'd7
   } l2_mode_e;

   // one port's slice of the control word: mode in [3:1], edge select in [0]
   typedef struct packed {
      l2_mode_e mode;
      logic     l1_rise;
   } port_cfg_t;

   function automatic logic mode_is_input(input l2_mode_e m);
      return m inside {L2_IN_NEG, L2_IN_NEG_IND, L2_IN_POS, L2_IN_POS_IND};
   endfunction

   function automatic logic mode_is_rising(input l2_mode_e m);
      return m inside {L2_IN_POS, L2_IN_POS_IND};
   endfunction

   function automatic logic mode_is_indep(input l2_mode_e m);
      return m inside {L2_IN_NEG_IND, L2_IN_POS_IND};
   endfunction

endpackage

// File: rtl/ctl_edge_det.sv
module ctl_edge_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   logic level;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         logic [SYNC_STAGES:0]   chain;
         assign chain = {sync_q, pin};
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= {SYNC_STAGES{pin}};
            end else begin
               sync_q <= chain[SYNC_STAGES-1:0];
            end
         end
         assign level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= pin;
      end else begin
         prev_q <= level;
      end
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

endmodule

// File: rtl/ctl_l2_driver.sv
module ctl_l2_driver
   import ctl_line_pkg::*;
#(
   parameter int PULSE_CYCLES = 1,
   localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  l2_mode_e mode,
   input  logic     arm,
   input  logic     partner_toggle,
   output logic     drv_out,
   output logic     drv_oe
);

   localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYCLES);

   logic             hs_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= 1'b1;
      end else if (mode != L2_HANDSHAKE) begin
         hs_q <= 1'b1;
      end else if (arm) begin
         hs_q <= 1'b0;
      end else if (partner_toggle) begin
         hs_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (mode != L2_PULSE) begin
         cnt_q <= '0;
      end else if (arm) begin
         cnt_q <= PULSE_LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      drv_oe = ~mode_is_input(mode);
      unique case (mode)
         L2_HANDSHAKE: drv_out = hs_q;
         L2_PULSE:     drv_out = (cnt_q == '0);
         L2_FORCE_LO:  drv_out = 1'b0;
         default:      drv_out = 1'b1;
      endcase
   end

endmodule

// File: rtl/ctl_port_slice.sv
module ctl_port_slice
   import ctl_line_pkg::*;
#(
   parameter int SYNC_STAGES  = 0,
   parameter int PULSE_CYCLES = 1,
   parameter bit HONOR_INDEP  = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  port_cfg_t cfg,
   input  logic      l1_pin,
   input  logic      l2_pin,
   input  logic      acc,
   output logic      flag1,
   output logic      flag2,
   output logic      l2_out,
   output logic      l2_oe
);

   logic l1_rise, l1_fall, l2_rise, l2_fall;
   logic hit1, hit2, keep2;
   logic flag1_q, flag2_q;

   ctl_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_l1_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (l1_pin),
      .rise (l1_rise),
      .fall (l1_fall)
   );

   ctl_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_l2_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (l2_pin),
      .rise (l2_rise),
      .fall (l2_fall)
   );

   assign hit1 = cfg.l1_rise ? l1_rise : l1_fall;
   assign hit2 = mode_is_input(cfg.mode) &
                 (mode_is_rising(cfg.mode) ? l2_rise : l2_fall);

   generate
      if (HONOR_INDEP) begin : g_indep
         assign keep2 = mode_is_indep(cfg.mode);
      end else begin : g_always_clear
         assign keep2 = 1'b0;
      end
   endgenerate

   // a new event outranks the clear from a same-cycle access
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag1_q <= 1'b0;
         flag2_q <= 1'b0;
      end else begin
         if (hit1)     flag1_q <= 1'b1;
         else if (acc) flag1_q <= 1'b0;
         if (hit2)                 flag2_q <= 1'b1;
         else if (acc && !keep2)   flag2_q <= 1'b0;
      end
   end

   assign flag1 = flag1_q;
   assign flag2 = flag2_q;

   ctl_l2_driver #(.PULSE_CYCLES(PULSE_CYCLES)) u_drv (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode          (cfg.mode),
      .arm           (acc),
      .partner_toggle(l1_rise | l1_fall),
      .drv_out       (l2_out),
      .drv_oe        (l2_oe)
   );

endmodule

// File: rtl/ctl_line_unit.sv
module ctl_line_unit
   import ctl_line_pkg::*;
#(
   parameter int             PORTS        = 2,
   parameter int             SYNC_STAGES  = 0,
   parameter int             PULSE_CYCLES = 1,
   parameter logic [PORTS-1:0] INDEP_MASK = PORTS'(1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [PORTS*FIELD_W-1:0] cfg_wdata,
   input  logic [PORTS-1:0]         port_acc,
   input  logic [PORTS-1:0]         l1_in,
   input  logic [PORTS-1:0]         l2_in,
   output logic [PORTS-1:0]         flag_l1,
   output logic [PORTS-1:0]         flag_l2,
   output logic [PORTS-1:0]         l2_out,
   output logic [PORTS-1:0]         l2_oe
);

   localparam int CTRL_W = PORTS * FIELD_W;

   initial begin
      assert (PORTS >= 1) else $error("PORTS must be at least 1");
      assert (SYNC_STAGES >= 0) else $error("SYNC_STAGES must not be negative");
      assert (PULSE_CYCLES >= 1) else $error("PULSE_CYCLES must be at least 1");
   end

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (cfg_wr) begin
         ctrl_q <= cfg_wdata;
      end
   end

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         port_cfg_t pcfg;
         assign pcfg = port_cfg_t'(ctrl_q[p*FIELD_W +: FIELD_W]);

         ctl_port_slice #(
            .SYNC_STAGES (SYNC_STAGES),
            .PULSE_CYCLES(PULSE_CYCLES),
            .HONOR_INDEP (INDEP_MASK[p])
         ) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (pcfg),
            .l1_pin(l1_in[p]),
            .l2_pin(l2_in[p]),
            .acc   (port_acc[p]),
            .flag1 (flag_l1[p]),
            .flag2 (flag_l2[p]),
            .l2_out(l2_out[p]),
            .l2_oe (l2_oe[p])
         );
      end
   endgenerate

endmodule

// File: rtl/ctl_line_unit_chk.sv
module ctl_line_unit_chk #(
   parameter int               PORTS        = 2,
   parameter int               SYNC_STAGES  = 0,
   parameter int               PULSE_CYCLES = 1,
   parameter logic [PORTS-1:0] INDEP_MASK   = PORTS'(1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_wr,
   input logic [PORTS*4-1:0] ctrl_q,
   input logic [PORTS-1:0]   port_acc,
   input logic [PORTS-1:0]   l1_in,
   input logic [PORTS-1:0]   l2_in,
   input logic [PORTS-1:0]   flag_l1,
   input logic [PORTS-1:0]   flag_l2,
   input logic [PORTS-1:0]   l2_out,
   input logic [PORTS-1:0]   l2_oe
);

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_p
         logic [2:0] md;
         assign md = ctrl_q[p*4+1 +: 3];

         // R10
         input_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md < 3'd4) |-> (!l2_oe[p] && l2_out[p]));

         // R9
         forced_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md >= 3'd6) |-> (l2_oe[p] && (l2_out[p] == md[0])));

         // R7
         handshake_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md == 3'd4 && port_acc[p] && !cfg_wr) |=> !l2_out[p]);

         // R8
         pulse_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (md == 3'd5 && port_acc[p] && !cfg_wr) |=> !l2_out[p]);

         // R4
         no_out_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_l2[p]) |-> ($past(ctrl_q[p*4+3]) == 1'b0));

         if (PULSE_CYCLES == 1) begin : g_one
            // R8
            pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (md == 3'd5 && !l2_out[p] && !port_acc[p] && !cfg_wr) |=> l2_out[p]);
         end

         if (INDEP_MASK[p]) begin : g_ind
            // R6
            indep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (port_acc[p] && flag_l2[p] && md < 3'd4 && md[0]) |=> flag_l2[p]);
         end

         if (SYNC_STAGES == 0) begin : g_raw
            // R3
            l1_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(flag_l1[p]) |->
                  ($past(ctrl_q[p*4]) ? ($past(l1_in[p]) && !$past(l1_in[p], 2))
                                      : (!$past(l1_in[p]) && $past(l1_in[p], 2))));

            // R5
            acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (port_acc[p] && (l1_in[p] == $past(l1_in[p]))) |=> !flag_l1[p]);
         end
      end
   endgenerate

endmodule

bind ctl_line_unit ctl_line_unit_chk #(
   .PORTS       (PORTS),
   .SYNC_STAGES (SYNC_STAGES),
   .PULSE_CYCLES(PULSE_CYCLES),
   .INDEP_MASK  (INDEP_MASK)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_wr  (cfg_wr),
   .ctrl_q  (ctrl_q),
   .port_acc(port_acc),
   .l1_in   (l1_in),
   .l2_in   (l2_in),
   .flag_l1 (flag_l1),
   .flag_l2 (flag_l2),
   .l2_out  (l2_out),
   .l2_oe   (l2_oe)
);

// File: tb/ctl_line_unit_tb.sv
`timescale 1ns/1ps
module ctl_line_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [1:0] port_acc = 2'b00;
   logic [1:0] l1_in = 2'b11;
   logic [1:0] l2_in = 2'b01;
   logic [1:0] flag_l1, flag_l2, l2_out, l2_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ctl_line_unit dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_wdata(cfg_wdata),
      .port_acc (port_acc),
      .l1_in    (l1_in),
      .l2_in    (l2_in),
      .flag_l1  (flag_l1),
      .flag_l2  (flag_l2),
      .l2_out   (l2_out),
      .l2_oe    (l2_oe)
   );

   // requirement-level model
   localparam int PULSE = 1;
   logic [7:0] m_ctrl;
   logic [1:0] m_pl1, m_pl2, m_f1, m_f2, m_hs;
   int         m_cnt [2];

   task automatic model_reset();
      m_ctrl = 8'h00; m_f1 = 2'b00; m_f2 = 2'b00; m_hs = 2'b11;
      m_cnt[0] = 0; m_cnt[1] = 0;
      m_pl1 = l1_in; m_pl2 = l2_in;
   endtask

   task automatic model_step(input logic [1:0] l1, input logic [1:0] l2,
                             input logic [1:0] acc, input logic wr, input logic [7:0] wd);
      for (int p = 0; p < 2; p++) begin
         logic e, h1, h2, keep;
         logic [2:0] md;
         e  = m_ctrl[p*4];
         md = m_ctrl[p*4+1 +: 3];
         h1 = e ? (!m_pl1[p] && l1[p]) : (m_pl1[p] && !l1[p]);
         h2 = (md < 3'd4) && (md[1] ? (!m_pl2[p] && l2[p]) : (m_pl2[p] && !l2[p]));
         keep = (p == 0) && (md < 3'd4) && md[0];
         if (h1) m_f1[p] = 1'b1; else if (acc[p]) m_f1[p] = 1'b0;
         if (h2) m_f2[p] = 1'b1; else if (acc[p] && !keep) m_f2[p] = 1'b0;
         if (md != 3'd4) m_hs[p] = 1'b1;
         else if (acc[p]) m_hs[p] = 1'b0;
         else if (l1[p] != m_pl1[p]) m_hs[p] = 1'b1;
         if (md != 3'd5) m_cnt[p] = 0;
         else if (acc[p]) m_cnt[p] = PULSE;
         else if (m_cnt[p] > 0) m_cnt[p] = m_cnt[p] - 1;
      end
      m_pl1 = l1; m_pl2 = l2;
      if (wr) m_ctrl = wd;
   endtask

   function automatic logic exp_out(input int p);
      logic [2:0] md;
      md = m_ctrl[p*4+1 +: 3];
      case (md)
         3'd4:    return m_hs[p];
         3'd5:    return (m_cnt[p] == 0);
         3'd6:    return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      for (int p = 0; p < 2; p++) begin
         logic [2:0] md;
         string rq;
         md = m_ctrl[p*4+1 +: 3];
         rq = (md == 3'd4) ? "R7" : (md == 3'd5) ? "R8" : (md >= 3'd6) ? "R9" : "R10";
         check("R3", "flag_l1", {7'd0, flag_l1[p]}, {7'd0, m_f1[p]});
         check("R4", "flag_l2", {7'd0, flag_l2[p]}, {7'd0, m_f2[p]});
         check(rq, "l2_out", {7'd0, l2_out[p]}, {7'd0, exp_out(p)});
         check("R10", "l2_oe", {7'd0, l2_oe[p]}, {7'd0, md[2]});
      end
   endtask

   // called just after a falling edge
   task automatic step(input logic [1:0] l1, input logic [1:0] l2, input logic [1:0] acc,
                       input logic wr, input logic [7:0] wd);
      l1_in = l1; l2_in = l2; port_acc = acc; cfg_wr = wr; cfg_wdata = wd;
      @(posedge clk);
      model_step(l1, l2, acc, wr, wd);
      @(negedge clk);
      port_acc = 2'b00; cfg_wr = 1'b0;
      compare();
   endtask

   task automatic idle();
      step(l1_in, l2_in, 2'b00, 1'b0, 8'h00);
   endtask

   task automatic wcfg(input logic [7:0] v);
      step(l1_in, l2_in, 2'b00, 1'b1, v);
   endtask

   task automatic access(input logic [1:0] a);
      step(l1_in, l2_in, a, 1'b0, 8'h00);
   endtask

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      // R1 reset state
      check("R1", "flag_l1", {6'd0, flag_l1}, 8'h00);
      check("R1", "flag_l2", {6'd0, flag_l2}, 8'h00);
      check("R1", "l2_oe", {6'd0, l2_oe}, 8'h00);
      check("R1", "l2_out", {6'd0, l2_out}, 8'h03);
      idle();
      check("R1", "no false edge", {4'd0, flag_l1, flag_l2}, 8'h00);

      // R2 control layout
      wcfg(8'hE9);
      check("R2", "l2_oe", {6'd0, l2_oe}, 8'h03);
      check("R2", "l2_out", {6'd0, l2_out}, 8'h03);

      // R3 edge selects
      wcfg(8'h01);
      step(2'b10, l2_in, 2'b00, 1'b0, 8'h00);
      check("R3", "A falls under rising select", {7'd0, flag_l1[0]}, 8'h00);
      step(2'b11, l2_in, 2'b00, 1'b0, 8'h00);
      check("R3", "A rises", {7'd0, flag_l1[0]}, 8'h01);
      step(2'b01, l2_in, 2'b00, 1'b0, 8'h00);
      check("R3", "B falls", {7'd0, flag_l1[1]}, 8'h01);

      // R5 port B clear, set wins
      step(l1_in, 2'b11, 2'b00, 1'b0, 8'h00);
      step(l1_in, 2'b01, 2'b00, 1'b0, 8'h00);
      check("R4", "B line2 fall", {7'd0, flag_l2[1]}, 8'h01);
      access(2'b10);
      check("R5", "B flags cleared", {6'd0, flag_l1[1], flag_l2[1]}, 8'h00);
      check("R5", "A flag untouched", {7'd0, flag_l1[0]}, 8'h01);
      step(2'b11, l2_in, 2'b00, 1'b0, 8'h00);
      step(2'b01, l2_in, 2'b10, 1'b0, 8'h00);
      check("R5", "set beats clear", {7'd0, flag_l1[1]}, 8'h01);

      // R6 independent mode on port A
      wcfg(8'h03);
      step(l1_in, 2'b00, 2'b00, 1'b0, 8'h00);
      check("R6", "A line2 flag set", {7'd0, flag_l2[0]}, 8'h01);
      access(2'b01);
      check("R6", "indep keeps line2", {7'd0, flag_l2[0]}, 8'h01);
      check("R6", "line1 cleared", {7'd0, flag_l1[0]}, 8'h00);
      wcfg(8'h01);
      access(2'b01);
      check("R6", "dependent clears line2", {7'd0, flag_l2[0]}, 8'h00);

      // R7 handshake
      wcfg(8'h08);
      access(2'b01);
      check("R7", "low after access", {7'd0, l2_out[0]}, 8'h00);
      step(2'b00, l2_in, 2'b00, 1'b0, 8'h00);
      check("R7", "high after line1 change", {7'd0, l2_out[0]}, 8'h01);
      step(2'b01, l2_in, 2'b01, 1'b0, 8'h00);
      check("R7", "access wins", {7'd0, l2_out[0]}, 8'h00);

      // R11 idle return
      wcfg(8'h00);
      wcfg(8'h08);
      check("R11", "handshake restarts high", {7'd0, l2_out[0]}, 8'h01);

      // R8 pulse
      wcfg(8'h0A);
      access(2'b01);
      check("R8", "pulse low", {7'd0, l2_out[0]}, 8'h00);
      idle();
      check("R8", "pulse ends", {7'd0, l2_out[0]}, 8'h01);
      access(2'b01);
      access(2'b01);
      check("R8", "restart", {7'd0, l2_out[0]}, 8'h00);

      // R9 forced levels
      wcfg(8'hEC);
      check("R9", "l2_out", {6'd0, l2_out}, 8'h02);
      check("R9", "l2_oe", {6'd0, l2_oe}, 8'h03);
      step(l1_in, 2'b11, 2'b00, 1'b0, 8'h00);

      // R10 / R4 input rising mode
      wcfg(8'h44);
      check("R10", "l2_oe", {6'd0, l2_oe}, 8'h00);
      check("R10", "l2_out", {6'd0, l2_out}, 8'h03);
      access(2'b11);
      step(l1_in, 2'b00, 2'b00, 1'b0, 8'h00);
      check("R4", "fall ignored in rising mode", {6'd0, flag_l2}, 8'h00);
      step(l1_in, 2'b11, 2'b00, 1'b0, 8'h00);
      check("R4", "rise sets", {6'd0, flag_l2}, 8'h03);

      // random stretch against the model
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] nl1, nl2, na;
         logic nw;
         nl1 = l1_in ^ {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
         nl2 = l2_in ^ {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
         na  = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
         nw  = ($urandom_range(0, 39) == 0);
         step(nl1, nl2, na, nw, 8'($urandom_range(0, 255)));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule